// File: doc/BRIEF.md
# Drive status packer and command decoder

This block links a disc drive mechanism to the host that controls it. In one direction it packs the drive's current report into a ten-byte status area. The report is a status word, three 16-bit position fields and an extension byte. A 4-bit checksum is appended, and an interrupt request is raised when one is enabled. In the other direction it decodes the opcode byte and the argument byte of an incoming command into a one-cycle, one-hot operation strobe for the mechanism's own logic. Table-of-contents and position queries also leave a sub-code in the low byte of the status word that the next report carries.

An export is run by a two-state sequencer. In `EX_IDLE`, a pulse on `exp_go` latches the field inputs, clears the upper six bits of the drive control byte, and moves to `EX_PACK`. In `EX_PACK` the checksum is formed over the latched bytes and the status area is written. The sequencer then returns unconditionally to `EX_IDLE`. Command decoding is independent of the sequencer.

Top module: `drv_link`

## Requirements
- R1: After reset every byte of `stat_area` is zero except byte 9, which is 0x0F; `irq_req`, `op_strobe` and `ctl_q` are zero.
- R2: An export accepted at a rising edge updates `stat_area` at the next rising edge. Byte i is `stat_area[8*i+7:8*i]`. Bytes 0/1 are the status word low/high: the low byte is the held sub-code and the high byte is `st_hi`. Bytes 2/3 hold minute, 4/5 second and 6/7 frame, each low byte first. Byte 8 is `st_ext`.
- R3: Byte 9 holds in its low nibble the bit inverse of the low four bits of the sum of bytes 0 to 8; its upper nibble is zero.
- R4: `irq_req` is high for exactly the one cycle in which a new status area first appears, and only if `irq_en` was high when the export was accepted.
- R5: A write (`ctl_we`) loads `ctl_wd` into `ctl_q`. Every accepted export clears `ctl_q[7:2]`. A write and an accepted export at the same edge store `ctl_wd & 8'h03`.
- R6: `exp_go` in the cycle after an accepted export (state `EX_PACK`) is ignored.
- R7: A command on `cmd_go` raises exactly one bit of `op_strobe` for the single following cycle. Opcode to bit: 0x00→0 (status), 0x01→1 (stop), 0x02→2 (query), 0x03→3 (read), 0x04→4 (seek), 0x06→5 (pause), 0x07→6 (resume), 0x08→7 (fast forward), 0x09→8 (rewind), 0x0A→9 (recover), 0x0C→10 (close tray), 0x0D→11 (open tray).
- R8: Every other opcode (0x05, 0x0B, 0x0E, 0x0F and all values from 0x10 up) raises bit 12 (unknown).
- R9: A query (opcode 0x02) with argument 0 to 5 raises bit 2 and sets the held sub-code to the argument.
- R10: A query with an argument above 5 raises bit 0 (plain status) and sets the held sub-code to 0x0F.
- R11: Non-query commands leave the held sub-code unchanged.
- R12: When a command and an export are accepted at the same edge, the export carries the sub-code held before that command; the new sub-code appears in the next export.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exp_go | input | 1 | Start an export |
| irq_en | input | 1 | Interrupt enable sampled at export acceptance |
| st_hi | input | 8 | Status word high byte |
| st_min | input | 16 | Minute field |
| st_sec | input | 16 | Second field |
| st_frm | input | 16 | Frame field |
| st_ext | input | 8 | Extension byte |
| ctl_we | input | 1 | Drive control byte write |
| ctl_wd | input | 8 | Drive control write data |
| cmd_go | input | 1 | Command present |
| cmd_op | input | 8 | Command opcode byte (area byte 0) |
| cmd_arg | input | 8 | Command argument byte (area byte 3) |
| stat_area | output | 80 | Ten-byte status area, byte 0 in bits 7:0 |
| irq_req | output | 1 | One-cycle interrupt request |
| ctl_q | output | 8 | Drive control byte |
| op_strobe | output | 13 | One-hot operation strobe |

## Verification
Two pairs of functions can collide in one cycle. A query and an export can both be accepted at the same edge. The bench provokes this by raising `cmd_go` and `exp_go` together. It judges the result by reading byte 0 of that export, which must hold the old sub-code, and of the following export, which must hold the new one. The second pair is a control byte write at the same edge as an accepted export; here `ctl_q` must come out as the written value masked to two bits.

// File: rtl/drv_link_pkg.sv
package drv_link_pkg;
    localparam int BYTE_W     = 8;
    localparam int FIELD_W    = 16;
    localparam int CSUM_W     = 4;
    localparam int DATA_BYTES = 9;
    localparam int AREA_BYTES = DATA_BYTES + 1;
    localparam int AREA_W     = AREA_BYTES * BYTE_W;
    localparam int OP_N       = 13;
    localparam int QRY_MAX    = 5;
    localparam logic [BYTE_W-1:0] QRY_BAD = 8'h0F;

    typedef enum logic [3:0] {
        OP_STATUS  = 4'd0,
        OP_STOP    = 4'd1,
        OP_QUERY   = 4'd2,
        OP_READ    = 4'd3,
        OP_SEEK    = 4'd4,
        OP_PAUSE   = 4'd5,
        OP_RESUME  = 4'd6,
        OP_FFWD    = 4'd7,
        OP_REWIND  = 4'd8,
        OP_RECOVER = 4'd9,
        OP_CLOSE   = 4'd10,
        OP_OPEN    = 4'd11,
        OP_UNKNOWN = 4'd12
    } op_e;

    typedef enum logic [0:0] {
        EX_IDLE = 1'b0,
        EX_PACK = 1'b1
    } ex_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0]  ext;
        logic [FIELD_W-1:0] frm;
        logic [FIELD_W-1:0] sec;
        logic [FIELD_W-1:0] min;
        logic [BYTE_W-1:0]  word_hi;
        logic [BYTE_W-1:0]  word_lo;
    } stat_fields_t;
endpackage

// File: rtl/drv_csum.sv
module drv_csum #(
    parameter int NBYTES = 9,
    parameter int SW     = 4
) (
    input  logic [8*NBYTES-1:0] bytes_in,
    output logic [SW-1:0]       csum
);
    logic [SW-1:0] part [0:NBYTES];

    assign part[0] = '0;

    for (genvar gi = 0; gi < NBYTES; gi++) begin : g_lane
        assign part[gi+1] = part[gi] + SW'(bytes_in[8*gi +: 8]);
    end

    assign csum = ~part[NBYTES];
endmodule

// File: rtl/drv_cmd_dec.sv
module drv_cmd_dec
    import drv_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic [BYTE_W-1:0] cmd_op,
    input  logic [BYTE_W-1:0] cmd_arg,
    output logic [OP_N-1:0]   op_strobe,
    output logic [BYTE_W-1:0] sub_q
);
    op_e               op_sel;
    logic              sub_wr;
    logic [BYTE_W-1:0] sub_nxt;

    always_comb begin
        op_sel  = OP_UNKNOWN;
        sub_wr  = 1'b0;
        sub_nxt = sub_q;
        case (cmd_op)
            8'h00: op_sel = OP_STATUS;
            8'h01: op_sel = OP_STOP;
            8'h02: begin
                sub_wr = 1'b1;
                if (cmd_arg <= BYTE_W'(QRY_MAX)) begin
                    op_sel  = OP_QUERY;
                    sub_nxt = cmd_arg;
                end else begin
                    op_sel  = OP_STATUS;
                    sub_nxt = QRY_BAD;
                end
            end
            8'h03: op_sel = OP_READ;
            8'h04: op_sel = OP_SEEK;
            8'h06: op_sel = OP_PAUSE;
            8'h07: op_sel = OP_RESUME;
            8'h08: op_sel = OP_FFWD;
            8'h09: op_sel = OP_REWIND;
            8'h0A: op_sel = OP_RECOVER;
            8'h0C: op_sel = OP_CLOSE;
            8'h0D: op_sel = OP_OPEN;
            default: op_sel = OP_UNKNOWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_strobe <= '0;
            sub_q     <= '0;
        end else begin
            op_strobe <= cmd_go ? (OP_N'(1) << op_sel) : '0;
            if (cmd_go && sub_wr) begin
                sub_q <= sub_nxt;
            end
        end
    end

    a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_strobe));

    a_r7_strobe_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (|op_strobe) |-> $past(cmd_go));

    a_r10_sub_range: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_q <= BYTE_W'(QRY_MAX)) || (sub_q == QRY_BAD));

    a_r11_sub_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_go |=> $stable(sub_q));
endmodule

// File: rtl/drv_export.sv
module drv_export
    import drv_link_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exp_go,
    input  logic               irq_en,
    input  logic [BYTE_W-1:0]  st_hi,
    input  logic [FIELD_W-1:0] st_min,
    input  logic [FIELD_W-1:0] st_sec,
    input  logic [FIELD_W-1:0] st_frm,
    input  logic [BYTE_W-1:0]  st_ext,
    input  logic [BYTE_W-1:0]  sub_q,
    input  logic               ctl_we,
    input  logic [BYTE_W-1:0]  ctl_wd,
    output logic [AREA_W-1:0]  area_q,
    output logic               irq_q,
    output logic [BYTE_W-1:0]  ctl_q
);
    localparam logic [AREA_W-1:0] AREA_RST =
        {{(BYTE_W-CSUM_W){1'b0}}, {CSUM_W{1'b1}}, {(DATA_BYTES*BYTE_W){1'b0}}};
    localparam logic [BYTE_W-1:0] CTL_KEEP = 8'h03;

    ex_state_e     state_q, state_d;
    stat_fields_t  stg_q;
    logic          ien_q;
    logic          accept;
    logic [CSUM_W-1:0] csum_w;

    assign accept = (state_q == EX_IDLE) && exp_go;

    drv_csum #(.NBYTES(DATA_BYTES), .SW(CSUM_W)) u_csum (
        .bytes_in (stg_q),
        .csum     (csum_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EX_IDLE: state_d = exp_go ? EX_PACK : EX_IDLE;
            EX_PACK: state_d = EX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q  <= '0;
            ien_q  <= 1'b0;
            area_q <= AREA_RST;
            irq_q  <= 1'b0;
            ctl_q  <= '0;
        end else begin
            irq_q <= 1'b0;
            if (accept) begin
                stg_q <= stat_fields_t'({st_ext, st_frm, st_sec, st_min, st_hi, sub_q});
                ien_q <= irq_en;
            end
            if (state_q == EX_PACK) begin
                area_q <= {{(BYTE_W-CSUM_W){1'b0}}, csum_w, stg_q};
                irq_q  <= ien_q;
            end
            if (ctl_we) begin
                ctl_q <= accept ? (ctl_wd & CTL_KEEP) : ctl_wd;
            end else if (accept) begin
                ctl_q <= ctl_q & CTL_KEEP;
            end
        end
    end

    a_r4_irq_after_pack: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> ($past(state_q) == EX_PACK));

    a_r2_area_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != EX_PACK) |=> $stable(area_q));

    a_r5_ctl_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EX_PACK) |-> (ctl_q[BYTE_W-1:2] == '0));

    a_r6_pack_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EX_PACK) |=> (state_q == EX_IDLE));
endmodule

// File: rtl/drv_link.sv
module drv_link
    import drv_link_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exp_go,
    input  logic               irq_en,
    input  logic [BYTE_W-1:0]  st_hi,
    input  logic [FIELD_W-1:0] st_min,
    input  logic [FIELD_W-1:0] st_sec,
    input  logic [FIELD_W-1:0] st_frm,
    input  logic [BYTE_W-1:0]  st_ext,
    input  logic               ctl_we,
    input  logic [BYTE_W-1:0]  ctl_wd,
    input  logic               cmd_go,
    input  logic [BYTE_W-1:0]  cmd_op,
    input  logic [BYTE_W-1:0]  cmd_arg,
    output logic [AREA_W-1:0]  stat_area,
    output logic               irq_req,
    output logic [BYTE_W-1:0]  ctl_q,
    output logic [OP_N-1:0]    op_strobe
);
    logic [BYTE_W-1:0] sub_w;

    drv_cmd_dec u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_go    (cmd_go),
        .cmd_op    (cmd_op),
        .cmd_arg   (cmd_arg),
        .op_strobe (op_strobe),
        .sub_q     (sub_w)
    );

    drv_export u_exp (
        .clk    (clk),
        .rst_n  (rst_n),
        .exp_go (exp_go),
        .irq_en (irq_en),
        .st_hi  (st_hi),
        .st_min (st_min),
        .st_sec (st_sec),
        .st_frm (st_frm),
        .st_ext (st_ext),
        .sub_q  (sub_w),
        .ctl_we (ctl_we),
        .ctl_wd (ctl_wd),
        .area_q (stat_area),
        .irq_q  (irq_req),
        .ctl_q  (ctl_q)
    );
endmodule

// File: tb/test_drv_link.sv
module test_drv_link;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exp_go = 1'b0, irq_en = 1'b0;
    logic [7:0]  st_hi = '0, st_ext = '0;
    logic [15:0] st_min = '0, st_sec = '0, st_frm = '0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wd = '0;
    logic        cmd_go = 1'b0;
    logic [7:0]  cmd_op = '0, cmd_arg = '0;
    logic [79:0] stat_area;
    logic        irq_req;
    logic [7:0]  ctl_q;
    logic [12:0] op_strobe;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] sub_m = 8'h00;

    always #(CLK_P/2) clk = ~clk;

    drv_link i_drv_link (
        .clk(clk), .rst_n(rst_n), .exp_go(exp_go), .irq_en(irq_en),
        .st_hi(st_hi), .st_min(st_min), .st_sec(st_sec), .st_frm(st_frm),
        .st_ext(st_ext), .ctl_we(ctl_we), .ctl_wd(ctl_wd), .cmd_go(cmd_go),
        .cmd_op(cmd_op), .cmd_arg(cmd_arg), .stat_area(stat_area),
        .irq_req(irq_req), .ctl_q(ctl_q), .op_strobe(op_strobe)
    );

    task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [79:0] mk_area(input logic [7:0] lo, input logic [7:0] hi,
        input logic [15:0] mi, input logic [15:0] se, input logic [15:0] fr, input logic [7:0] ex);
        logic [71:0] d;
        int s;
        logic [3:0] cs;
        d = {ex, fr, se, mi, hi, lo};
        s = 0;
        for (int i = 0; i < 9; i++) s += d[8*i +: 8];
        cs = ~s[3:0];
        return {4'h0, cs, d};
    endfunction

    function automatic int op_bit(input logic [7:0] op, input logic [7:0] arg);
        case (op)
            8'h00: return 0;
            8'h01: return 1;
            8'h02: return (arg <= 5) ? 2 : 0;
            8'h03: return 3;
            8'h04: return 4;
            8'h06: return 5;
            8'h07: return 6;
            8'h08: return 7;
            8'h09: return 8;
            8'h0A: return 9;
            8'h0C: return 10;
            8'h0D: return 11;
            default: return 12;
        endcase
    endfunction

    task automatic set_fields(input logic [7:0] hi, input logic [15:0] mi, input logic [15:0] se,
        input logic [15:0] fr, input logic [7:0] ex, input logic en);
        st_hi = hi; st_min = mi; st_sec = se; st_frm = fr; st_ext = ex; irq_en = en;
    endtask

    // drives one export, returns just after the edge that writes the area
    task automatic do_export(input logic [7:0] hi, input logic [15:0] mi, input logic [15:0] se,
        input logic [15:0] fr, input logic [7:0] ex, input logic en);
        @(negedge clk);
        set_fields(hi, mi, se, fr, ex, en);
        exp_go = 1'b1;
        @(negedge clk);
        exp_go = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_cmd(input logic [7:0] op, input logic [7:0] arg);
        @(negedge clk);
        cmd_op = op; cmd_arg = arg; cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
        if (op == 8'h02) sub_m = (arg <= 5) ? arg : 8'h0F;
    endtask

    task automatic t_reset;
        chk(stat_area == {8'h0F, 72'h0}, "R1 area", stat_area, {8'h0F, 72'h0});
        chk(irq_req == 1'b0 && op_strobe == '0, "R1 irq/op", {irq_req, op_strobe}, '0);
        chk(ctl_q == 8'h00, "R1 ctl", ctl_q, 8'h00);
    endtask

    task automatic t_export_basic;
        logic [79:0] e;
        do_export(8'h5A, 16'h1234, 16'hBEEF, 16'h0071, 8'h9C, 1'b1);
        e = mk_area(sub_m, 8'h5A, 16'h1234, 16'hBEEF, 16'h0071, 8'h9C);
        chk(stat_area == e, "R2 R3 layout/csum", stat_area, e);
        chk(irq_req == 1'b1, "R4 irq pulse", irq_req, 1);
        @(negedge clk);
        chk(irq_req == 1'b0, "R4 irq one cycle", irq_req, 0);
        do_export(8'hFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 8'hFF, 1'b0);
        e = mk_area(sub_m, 8'hFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 8'hFF);
        chk(stat_area == e, "R3 all-ones csum", stat_area, e);
        chk(irq_req == 1'b0, "R4 irq disabled", irq_req, 0);
    endtask

    task automatic t_ctl;
        @(negedge clk); ctl_we = 1'b1; ctl_wd = 8'hFF;
        @(negedge clk); ctl_we = 1'b0;
        chk(ctl_q == 8'hFF, "R5 ctl write", ctl_q, 8'hFF);
        do_export(8'h01, 16'h2, 16'h3, 16'h4, 8'h5, 1'b0);
        chk(ctl_q == 8'h03, "R5 ctl masked on export", ctl_q, 8'h03);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wd = 8'hAE; exp_go = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0; exp_go = 1'b0;
        chk(ctl_q == 8'h02, "R5 write with export", ctl_q, 8'h02);
        @(negedge clk);
    endtask

    task automatic t_busy;
        logic [79:0] e;
        @(negedge clk);
        set_fields(8'h11, 16'h2222, 16'h3333, 16'h4444, 8'h55, 1'b1);
        exp_go = 1'b1;
        @(negedge clk);
        set_fields(8'hAA, 16'hBBBB, 16'hCCCC, 16'hDDDD, 8'hEE, 1'b1);
        @(negedge clk);
        exp_go = 1'b0;
        e = mk_area(sub_m, 8'h11, 16'h2222, 16'h3333, 16'h4444, 8'h55);
        chk(stat_area == e, "R6 first export kept", stat_area, e);
        @(negedge clk);
        chk(stat_area == e && irq_req == 1'b0, "R6 second go ignored", stat_area, e);
    endtask

    task automatic t_ops;
        logic [7:0] codes [18] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08,
                                   8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F, 8'h10, 8'hFF};
        for (int k = 0; k < 18; k++) begin
            logic [12:0] e;
            send_cmd(codes[k], 8'h00);
            e = 13'(1) << op_bit(codes[k], 8'h00);
            chk(op_strobe == e, (op_bit(codes[k], 8'h00) == 12) ? "R8 unknown op" : "R7 op decode", op_strobe, e);
            @(negedge clk);
            chk(op_strobe == '0, "R7 strobe one cycle", op_strobe, 0);
        end
    endtask

    task automatic t_query;
        logic [79:0] e;
        for (int a = 0; a <= 5; a++) begin
            send_cmd(8'h02, 8'(a));
            chk(op_strobe == 13'h004, "R9 query strobe", op_strobe, 13'h004);
            do_export(8'h80, 16'h0, 16'h0, 16'h0, 8'h0, 1'b0);
            chk(stat_area[7:0] == 8'(a), "R9 sub-code", stat_area[7:0], 8'(a));
        end
        send_cmd(8'h02, 8'h07);
        chk(op_strobe == 13'h001, "R10 bad query status", op_strobe, 13'h001);
        do_export(8'h80, 16'h0, 16'h0, 16'h0, 8'h0, 1'b0);
        e = mk_area(8'h0F, 8'h80, 16'h0, 16'h0, 16'h0, 8'h0);
        chk(stat_area == e, "R10 sub 0x0F", stat_area, e);
        send_cmd(8'h02, 8'h04);
        send_cmd(8'h03, 8'h02);
        send_cmd(8'h0D, 8'h01);
        do_export(8'h00, 16'h0, 16'h0, 16'h0, 8'h0, 1'b0);
        chk(stat_area[7:0] == 8'h04, "R11 sub held", stat_area[7:0], 8'h04);
    endtask

    task automatic t_same_cycle;
        send_cmd(8'h02, 8'h01);
        @(negedge clk);
        set_fields(8'h00, 16'h0, 16'h0, 16'h0, 8'h0, 1'b0);
        cmd_op = 8'h02; cmd_arg = 8'h05; cmd_go = 1'b1; exp_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0; exp_go = 1'b0;
        sub_m = 8'h05;
        @(negedge clk);
        chk(stat_area[7:0] == 8'h01, "R12 old sub-code", stat_area[7:0], 8'h01);
        do_export(8'h00, 16'h0, 16'h0, 16'h0, 8'h0, 1'b0);
        chk(stat_area[7:0] == 8'h05, "R12 new sub-code", stat_area[7:0], 8'h05);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_export_basic();
        t_ctl();
        t_busy();
        t_ops();
        t_query();
        t_same_cycle();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule